// File: doc/BRIEF.md
# Order-Statistic CFAR Detector

This block is a streaming radar detector for one range sweep at a time. It takes one unsigned magnitude sample per clock and keeps a sliding window around a cell under test (CUT). Two guard cells sit next to the CUT, one on each side. Beyond the guards lie sixteen reference cells, eight on each side. The noise level Z is the K-th smallest reference value. The block finds it without sorting. Each pass takes the largest remaining reference value and zeroes that one cell. After N-K+1 passes, the last maximum taken is Z.

Z is multiplied by a run-time scaling factor to form a threshold. The CUT is declared a target when it strictly exceeds that threshold. Each result carries the range index of the CUT, counted from the start of the sweep.

The passes are unrolled into a pipeline of selection stages, so a new range cell is accepted every clock. The CUT, its index and a valid flag travel alongside and stay aligned with the result. A sweep-start strobe restarts the window. Results are produced only for cells whose whole window lies inside the current sweep.

Top module: `os_cfar_det`

## Requirements
- R1: For the CUT at range index r, the reference set is the sixteen samples at r-9..r-2 and r+2..r+9 of the current sweep.
- R2: Z is the fifth largest of the sixteen reference values, which is the twelfth in ascending order. Duplicate values count separately.
- R3: Each selection pass zeroes exactly one cell. Among equal maxima, the cell with the lowest window position is zeroed. Five equal large values therefore make Z equal to that value, and four do not.
- R4: `thr_o` equals Z times `tos_i`, held at its full 20-bit width. `tos_i` is unsigned with 4 integer and 4 fractional bits, so `thr_o` carries 4 fractional bits. The product 4095 x 255 = 1044225 does not wrap.
- R5: `det_o` is 1 exactly when CUT x 16 > `thr_o`. Equality gives no detection. `det_o` is never high while `valid_o` is low.
- R6: The guard samples at r-1 and r+1 have no effect on the threshold, however large they are.
- R7: `valid_o` is high only for a CUT whose 19-sample window lies entirely inside the current sweep. A sweep of L cells yields results for indices 9..L-10, in increasing order. A sweep shorter than 19 cells yields none.
- R8: A cycle with `valid_i` and `sweep_i` both high starts a new sweep. That sample gets index 0, and no earlier sample enters any later result.
- R9: With `valid_i` held high, one result is produced per clock, so `valid_o` stays high on consecutive cycles. A cycle with `valid_i` low neither shifts the window nor advances the index.
- R10: While `rst_ni` is low, `valid_o` and `det_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | `data_i` holds a new range cell |
| sweep_i | input | 1 | With `valid_i`: this cell is index 0 of a new sweep |
| data_i | input | 12 | Unsigned magnitude sample |
| tos_i | input | 8 | Scaling factor, unsigned fixed point with 4 integer and 4 fractional bits |
| valid_o | output | 1 | Result valid |
| det_o | output | 1 | Target detected in the CUT |
| idx_o | output | 10 | Range index of the CUT within the sweep |
| thr_o | output | 20 | Threshold Z x `tos_i`, with 4 fractional bits |

## Verification
The assertions check several properties on every cycle:
- each selection pass zeroes exactly one nonzero cell, and no value left in the window exceeds the maximum that pass took;
- a valid result only ever comes from a full window, and its index is never below 9;
- a detection never appears without a valid result;
- a sweep start leaves only the new sample in the window;
- the threshold never falls below Z when the factor is at least one.

Only the bench's scenarios can show that the threshold equals the fifth largest reference value and that tie counting gives the right rank. They also show that the guards are excluded, that equality does not detect, and that results stay in order across idle cycles and sweep restarts. The bench checks these against a sorting model of each window.

// File: rtl/cfar_pkg.sv
package cfar_pkg;
  localparam int unsigned DATA_W_DEF = 12;
  localparam int unsigned N_SIDE_DEF = 8;
  localparam int unsigned N_GUARD_DEF = 1;
  localparam int unsigned K_DEF = 12;
  localparam int unsigned TOS_W_DEF = 8;
  localparam int unsigned TOS_F_DEF = 4;
  localparam int unsigned IDX_W_DEF = 10;

  function automatic int unsigned win_len(int unsigned lag, int unsigned lead, int unsigned guard);
    return lag + lead + 2 * guard + 1;
  endfunction
endpackage

// File: rtl/cfar_window.sv
module cfar_window #(
  parameter int unsigned DW     = 12,
  parameter int unsigned N_LAG  = 8,
  parameter int unsigned N_LEAD = 8,
  parameter int unsigned N_G    = 1,
  parameter int unsigned IDXW   = 10,
  localparam int unsigned NREF  = N_LAG + N_LEAD
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic                      sweep_i,
  input  logic [DW-1:0]             data_i,
  output logic                      vld_o,
  output logic [NREF-1:0][DW-1:0]   ref_o,
  output logic [DW-1:0]             cut_o,
  output logic [IDXW-1:0]           idx_o
);
  localparam int unsigned W       = cfar_pkg::win_len(N_LAG, N_LEAD, N_G);
  localparam int unsigned CUT_POS = N_LAG + N_G;
  localparam int unsigned CW      = $clog2(W + 1);
  localparam logic [CW-1:0] W_C   = CW'(W);

  // cell 0 holds the newest sample (highest range)
  logic [W-1:0][DW-1:0] win_q;
  logic [CW-1:0]        cnt_q, cnt_nxt;
  logic [IDXW-1:0]      nidx_q;
  logic                 vld_q;

  always_comb begin
    if (sweep_i)          cnt_nxt = CW'(1);
    else if (cnt_q == W_C) cnt_nxt = cnt_q;
    else                  cnt_nxt = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      cnt_q  <= '0;
      nidx_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= valid_i && (cnt_nxt == W_C);
      if (valid_i) begin
        cnt_q <= cnt_nxt;
        if (sweep_i) begin
          win_q    <= '0;
          win_q[0] <= data_i;
          nidx_q   <= '0;
        end else begin
          win_q  <= {win_q[W-2:0], data_i};
          nidx_q <= nidx_q + IDXW'(1);
        end
      end
    end
  end

  for (genvar j = 0; j < N_LAG; j++) begin : g_lag
    assign ref_o[j] = win_q[j];
  end
  for (genvar j = 0; j < N_LEAD; j++) begin : g_lead
    assign ref_o[N_LAG+j] = win_q[CUT_POS+N_G+1+j];
  end

  assign cut_o = win_q[CUT_POS];
  assign idx_o = nidx_q - IDXW'(CUT_POS);
  assign vld_o = vld_q;

  AST_SWEEP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && sweep_i) |-> (win_q[W-1:1] == '0) && (cnt_q == CW'(1))); // R8

  AST_VLD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (cnt_q == W_C)); // R7
endmodule

// File: rtl/cfar_max_stage.sv
module cfar_max_stage #(
  parameter int unsigned DW   = 12,
  parameter int unsigned N    = 16,
  parameter int unsigned IDXW = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   vld_i,
  input  logic [N-1:0][DW-1:0]   ref_i,
  input  logic [DW-1:0]          cut_i,
  input  logic [IDXW-1:0]        idx_i,
  output logic                   vld_o,
  output logic [N-1:0][DW-1:0]   ref_o,
  output logic [DW-1:0]          max_o,
  output logic [DW-1:0]          cut_o,
  output logic [IDXW-1:0]        idx_o
);
  localparam int unsigned PSW = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned ZCW = $clog2(N + 1);

  logic [DW-1:0]        best;
  logic [PSW-1:0]       pos;
  logic [N-1:0][DW-1:0] cleared;

  // strict compare: lowest position keeps a tie
  always_comb begin
    best = ref_i[0];
    pos  = '0;
    for (int j = 1; j < N; j++) begin
      if (ref_i[j] > best) begin
        best = ref_i[j];
        pos  = PSW'(j);
      end
    end
    cleared      = ref_i;
    cleared[pos] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      ref_o <= '0;
      max_o <= '0;
      cut_o <= '0;
      idx_o <= '0;
    end else begin
      vld_o <= vld_i;
      ref_o <= cleared;
      max_o <= best;
      cut_o <= cut_i;
      idx_o <= idx_i;
    end
  end

  logic [ZCW-1:0] zin, zout;
  logic           above;
  always_comb begin
    zin   = '0;
    zout  = '0;
    above = 1'b0;
    for (int j = 0; j < N; j++) begin
      zin  = zin + ZCW'(ref_i[j] == '0);
      zout = zout + ZCW'(ref_o[j] == '0);
      if (ref_o[j] > max_o) above = 1'b1;
    end
  end

  AST_ONE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_o != '0) |-> (zout == $past(zin) + ZCW'(1))); // R3

  AST_MAX_DOMINATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> !above); // R2
endmodule

// File: rtl/cfar_decide.sv
module cfar_decide #(
  parameter int unsigned DW   = 12,
  parameter int unsigned TW   = 8,
  parameter int unsigned TF   = 4,
  parameter int unsigned IDXW = 10,
  localparam int unsigned PW  = DW + TW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [DW-1:0]    z_i,
  input  logic [DW-1:0]    cut_i,
  input  logic [IDXW-1:0]  idx_i,
  input  logic [TW-1:0]    tos_i,
  output logic             vld_o,
  output logic             det_o,
  output logic [IDXW-1:0]  idx_o,
  output logic [PW-1:0]    thr_o
);
  localparam logic [TW-1:0] ONE = TW'(1) << TF;

  logic            vld1_q;
  logic [PW-1:0]   thr1_q;
  logic [DW-1:0]   cut1_q;
  logic [IDXW-1:0] idx1_q;
  logic [PW-1:0]   cut_scaled;

  assign cut_scaled = PW'({cut1_q, {TF{1'b0}}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld1_q <= 1'b0;
      thr1_q <= '0;
      cut1_q <= '0;
      idx1_q <= '0;
      vld_o  <= 1'b0;
      det_o  <= 1'b0;
      idx_o  <= '0;
      thr_o  <= '0;
    end else begin
      vld1_q <= vld_i;
      thr1_q <= PW'(z_i) * PW'(tos_i);
      cut1_q <= cut_i;
      idx1_q <= idx_i;
      vld_o  <= vld1_q;
      det_o  <= vld1_q && (cut_scaled > thr1_q);
      idx_o  <= idx1_q;
      thr_o  <= thr1_q;
    end
  end

  AST_DET_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o |-> vld_o); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(vld_i) && ($past(tos_i) >= ONE)) |-> (thr1_q >= PW'($past(z_i)))); // R4
endmodule

// File: rtl/os_cfar_det.sv
module os_cfar_det #(
  parameter int unsigned DATA_W  = cfar_pkg::DATA_W_DEF,
  parameter int unsigned N_LAG   = cfar_pkg::N_SIDE_DEF,
  parameter int unsigned N_LEAD  = cfar_pkg::N_SIDE_DEF,
  parameter int unsigned N_GUARD = cfar_pkg::N_GUARD_DEF,
  parameter int unsigned K_RANK  = cfar_pkg::K_DEF,
  parameter int unsigned TOS_W   = cfar_pkg::TOS_W_DEF,
  parameter int unsigned TOS_F   = cfar_pkg::TOS_F_DEF,
  parameter int unsigned IDX_W   = cfar_pkg::IDX_W_DEF,
  localparam int unsigned THR_W  = DATA_W + TOS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sweep_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TOS_W-1:0]  tos_i,
  output logic              valid_o,
  output logic              det_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [THR_W-1:0]  thr_o
);
  localparam int unsigned NREF   = N_LAG + N_LEAD;
  localparam int unsigned PASSES = NREF - K_RANK + 1;
  localparam int unsigned FIRST  = N_LEAD + N_GUARD;

  logic [PASSES:0]                         st_vld;
  logic [PASSES:0][NREF-1:0][DATA_W-1:0]   st_ref;
  logic [PASSES:0][DATA_W-1:0]             st_cut;
  logic [PASSES:0][IDX_W-1:0]              st_idx;
  logic [PASSES-1:0][DATA_W-1:0]           st_max;

  cfar_window #(
    .DW(DATA_W), .N_LAG(N_LAG), .N_LEAD(N_LEAD), .N_G(N_GUARD), .IDXW(IDX_W)
  ) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sweep_i(sweep_i),
    .data_i(data_i), .vld_o(st_vld[0]), .ref_o(st_ref[0]), .cut_o(st_cut[0]),
    .idx_o(st_idx[0])
  );

  for (genvar s = 0; s < PASSES; s++) begin : g_pass
    cfar_max_stage #(.DW(DATA_W), .N(NREF), .IDXW(IDX_W)) u_stage (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .vld_i(st_vld[s]), .ref_i(st_ref[s]), .cut_i(st_cut[s]), .idx_i(st_idx[s]),
      .vld_o(st_vld[s+1]), .ref_o(st_ref[s+1]), .max_o(st_max[s]),
      .cut_o(st_cut[s+1]), .idx_o(st_idx[s+1])
    );
  end

  cfar_decide #(.DW(DATA_W), .TW(TOS_W), .TF(TOS_F), .IDXW(IDX_W)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(st_vld[PASSES]),
    .z_i(st_max[PASSES-1]), .cut_i(st_cut[PASSES]), .idx_i(st_idx[PASSES]),
    .tos_i(tos_i), .vld_o(valid_o), .det_o(det_o), .idx_o(idx_o), .thr_o(thr_o)
  );

  logic rest_above;
  always_comb begin
    rest_above = 1'b0;
    for (int j = 0; j < NREF; j++)
      if (st_ref[PASSES][j] > st_max[PASSES-1]) rest_above = 1'b1;
  end

  AST_Z_IS_RANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_vld[PASSES] |-> !rest_above); // R2

  AST_FIRST_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (idx_o >= IDX_W'(FIRST))); // R7
endmodule

// File: tb/sim_os_cfar_det.sv
`timescale 1ns/1ps
module sim_os_cfar_det;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, sweep_i = 1'b0;
  logic [11:0] data_i = '0;
  logic [7:0]  tos_i = '0;
  logic        valid_o, det_o;
  logic [9:0]  idx_o;
  logic [19:0] thr_o;

  always #2 clk = ~clk;

  os_cfar_det u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sweep_i(sweep_i),
    .data_i(data_i), .tos_i(tos_i), .valid_o(valid_o), .det_o(det_o),
    .idx_o(idx_o), .thr_o(thr_o)
  );

  int nchk = 0, nerr = 0;
  int samp [0:1023];
  int got_det [0:1023];
  int got_thr [0:1023];
  int tos_cur = 16;
  int mon_next = 9, n_out = 0, n_det = 0, run = 0, maxrun = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // fifth largest of the 16 references, by full descending sort
  function automatic int exp_z(input int r);
    int v[16];
    int t;
    for (int j = 0; j < 8; j++) begin
      v[j]   = samp[r-2-j];
      v[8+j] = samp[r+2+j];
    end
    for (int a = 0; a < 15; a++)
      for (int b = 0; b < 15 - a; b++)
        if (v[b] < v[b+1]) begin t = v[b]; v[b] = v[b+1]; v[b+1] = t; end
    return v[4];
  endfunction

  always @(negedge clk) begin
    int r, z, et;
    if (rst_n) begin
      if (det_o && !valid_o) chk(1'b0, "R5 det without valid", 1, 0);
      if (valid_o) begin
        r = int'(idx_o);
        chk(r == mon_next, "R7 R9 index order", r, mon_next);
        mon_next = r + 1;
        z  = exp_z(r);
        et = z * tos_cur;
        chk(int'(thr_o) == et, "R1 R2 R4 threshold", int'(thr_o), et);
        chk(det_o == (samp[r] * 16 > et), "R5 decision", det_o, samp[r] * 16 > et);
        got_det[r] = det_o;
        got_thr[r] = int'(thr_o);
        n_out++;
        n_det += det_o;
        run++;
        if (run > maxrun) maxrun = run;
      end else run = 0;
    end
  end

  task automatic send(input int len, input int gap);
    mon_next = 9; n_out = 0; n_det = 0; maxrun = 0;
    for (int i = 0; i < 1024; i++) begin got_det[i] = -1; got_thr[i] = -1; end
    tos_i = tos_cur[7:0];
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      valid_i = 1'b1; sweep_i = (i == 0); data_i = samp[i][11:0];
      if (gap > 0 && (i % gap) == gap - 1) begin
        @(negedge clk);
        valid_i = 1'b0; sweep_i = 1'b0; data_i = 12'hfff;
      end
    end
    @(negedge clk);
    valid_i = 1'b0; sweep_i = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic fill(input int v);
    for (int i = 0; i < 1024; i++) samp[i] = v;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0 && det_o == 1'b0, "R10 reset outputs", {valid_o, det_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_random;
    int s = 12345;
    for (int i = 0; i < 300; i++) begin
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      samp[i] = (s >> 8) % 600;
      if ((i % 37) == 20) samp[i] = 3000 + (i % 900);
    end
    tos_cur = 40;
    send(300, 0);
    chk(n_out == 282, "R7 result count", n_out, 282);
    chk(maxrun == 282, "R9 one per clock", maxrun, 282);
    chk(n_det > 0, "R5 spikes detected", n_det, 1);
  endtask

  task automatic t_ties;
    fill(100); samp[50] = 101; tos_cur = 16;
    send(120, 0);
    chk(n_det == 1, "R5 equality no detect", n_det, 1);
    chk(got_det[50] == 1, "R5 cut above threshold", got_det[50], 1);
    // five equal large refs of CUT 35: Z = 300
    fill(100); for (int i = 40; i <= 44; i++) samp[i] = 300; samp[35] = 200;
    send(80, 0);
    chk(got_thr[35] == 4800, "R3 five copies rank", got_thr[35], 4800);
    chk(got_det[35] == 0, "R3 five copies no detect", got_det[35], 0);
    fill(100); for (int i = 40; i <= 43; i++) samp[i] = 300; samp[35] = 200;
    send(80, 0);
    chk(got_thr[35] == 1600, "R3 four copies rank", got_thr[35], 1600);
    chk(got_det[35] == 1, "R3 four copies detect", got_det[35], 1);
  endtask

  task automatic t_guard;
    fill(50); samp[100] = 120; tos_cur = 32;
    samp[99] = 4000; samp[101] = 4000;
    for (int i = 102; i <= 104; i++) samp[i] = 4000;
    send(150, 0);
    chk(got_thr[100] == 1600, "R6 guards excluded", got_thr[100], 1600);
    chk(got_det[100] == 1, "R6 detect beside large guards", got_det[100], 1);
  endtask

  task automatic t_overflow;
    fill(4095); tos_cur = 255;
    send(30, 0);
    chk(got_thr[9] == 1044225, "R4 full width product", got_thr[9], 1044225);
    chk(n_det == 0, "R4 R5 no detect at max", n_det, 0);
  endtask

  task automatic t_restart;
    fill(4000); tos_cur = 16;
    send(60, 0);
    fill(10); samp[20] = 500;
    send(40, 0);
    chk(n_out == 22, "R8 restart count", n_out, 22);
    chk(got_det[9] == 0 && got_thr[9] == 160, "R8 no stale samples", got_thr[9], 160);
    chk(got_det[20] == 1, "R8 new sweep detect", got_det[20], 1);
  endtask

  task automatic t_gaps;
    for (int i = 0; i < 60; i++) samp[i] = (i * 37) % 200;
    samp[30] = 2000; tos_cur = 24;
    send(60, 3);
    chk(n_out == 42, "R9 idle cycles hold", n_out, 42);
    chk(got_det[30] == 1, "R9 detect with gaps", got_det[30], 1);
  endtask

  task automatic t_short;
    fill(200); tos_cur = 16;
    send(18, 0);
    chk(n_out == 0, "R7 short sweep no result", n_out, 0);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    fill(0);
    t_reset;
    t_random;
    t_ties;
    t_guard;
    t_overflow;
    t_restart;
    t_gaps;
    t_short;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule